// File: doc/BRIEF.md
# Ring-Chained FIFO-to-Host DMA Engine

This engine drains a fixed local FIFO port into host memory by walking a closed ring of descriptors that live in host memory. Each descriptor is four consecutive 32-bit words read through a simple memory-read port: the host start address, the local (FIFO) address, the transfer size in bytes, and the next-descriptor pointer, whose low four bits carry flags. Because descriptors sit on 16-byte boundaries, those four bits are free. The last descriptor points back to the first, so the ring is never exhausted and the engine runs until software stops it.

Data moves in demand mode. A word is taken from the FIFO and written to host memory only in a cycle where the FIFO signals ready. The local address stays fixed for the whole descriptor, while the host address steps by four for each word. When a descriptor's count runs out, the engine can latch a sticky completion interrupt, and it then fetches the next descriptor. A small register port sets the descriptor pointer, starts, stops and clears the engine, and reports status. It also gives a live readback of the current host address, which software uses to find how far the ring has been filled.

Top module: `ring_dma`

## Requirements
- R1: After reset, the status register (address 1), the descriptor pointer (address 0) and the address readback (address 2) all read 0. `irq` is low, and `memRdReq` and `hostWrEn` are low.
- R2: A control write to address 1 with bit 0 (enable) and bit 1 (start) set, and bit 2 clear, starts an idle engine. The engine first issues exactly four reads at pointer+0, +4, +8 and +12, each held until `memRdValid`. No host write occurs before the fourth read of a descriptor completes.
- R3: A word moves only in a cycle where `fifoReady` is high. In that cycle `fifoRdEn` and `hostWrEn` are high together, and `hostWrData` carries `fifoData`. Words reach the host in FIFO order.
- R4: During a transfer, `fifoAddr` equals the descriptor's local address (field 1) for every word and never increments.
- R5: A descriptor moves size/4 words (size bits 1:0 are ignored). The words go to host start, start+4, start+8 and so on. Sizes above 65536 bytes are treated as 65536.
- R6: A descriptor whose size is below 4 bytes moves no words, and the engine goes straight on to fetch the next descriptor.
- R7: After a descriptor completes, the next one is fetched from the next pointer with bits 3:0 cleared. A ring that points back to its head repeats indefinitely.
- R8: When a descriptor completes and bit 1 of its next pointer is set, status bit 2 and `irq` go high on the following cycle and stay high. Descriptors without that flag leave them unchanged.
- R9: Status bit 2 clears only on a control write with bit 3 set, and status bit 3 clears only on a control write with bit 4 set. Control writes with those bits at 0 leave the flags unchanged.
- R10: A start with a descriptor pointer whose bits 3:0 are not zero sets status bit 3 (alignment error) and issues no memory read. The engine stays idle, with status bit 1 (busy) at 0.
- R11: A control write with bit 2 (abort) set, or with bit 0 clear, stops the engine in that cycle. No further reads or host writes follow, and status bits 1:0 read 0.
- R12: Address 2 reads the current host address. Whenever a word is written, it equals `hostWrAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select: 0 pointer, 1 control/status, 2 host address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| memRdReq | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Descriptor word address |
| memRdValid | input | 1 | Read data valid; completes the request |
| memRdData | input | 32 | Descriptor word |
| fifoReady | input | 1 | FIFO has a word (demand request) |
| fifoRdEn | output | 1 | FIFO word consumed this cycle |
| fifoAddr | output | 32 | Constant local FIFO address |
| fifoData | input | 32 | FIFO word |
| hostWrEn | output | 1 | Host memory write strobe |
| hostWrAddr | output | 32 | Host write address |
| hostWrData | output | 32 | Host write data |
| irq | output | 1 | Sticky completion interrupt |

## Verification
The hardest situation to reach is the transition between descriptors under stalls on both sides. In that window a descriptor's last word, the sticky interrupt, an optional software clear and the four-read refetch all fall within a few cycles. Short descriptors are a problem for the same reason: a size under four bytes has to chain without moving data. The stimulus builds rings of short descriptors with odd sizes and a zero-length entry, and withholds `memRdValid` and `fifoReady` at random on every cycle. It also issues interrupt clears and no-op control writes at random, so these events overlap in many orders. A single self-looping descriptor with an oversize count exercises the size clamp and the wrap.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } engState_t;

  // descriptor word order in memory
  localparam logic [1:0] FLD_HOST  = 2'd0;
  localparam logic [1:0] FLD_LOCAL = 2'd1;
  localparam logic [1:0] FLD_SIZE  = 2'd2;
  localparam logic [1:0] FLD_NEXT  = 2'd3;

  localparam int NEXT_IRQ_BIT = 1;
  localparam int DESC_ALIGN_W = 4;

  // control write bits
  localparam int CTL_ENABLE    = 0;
  localparam int CTL_START     = 1;
  localparam int CTL_ABORT     = 2;
  localparam int CTL_CLR_DONE  = 3;
  localparam int CTL_CLR_ALIGN = 4;

  localparam logic [1:0] REG_PTR  = 2'd0;
  localparam logic [1:0] REG_CSR  = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;

  typedef struct packed {
    logic       loadBase;
    logic       latchField;
    logic [1:0] fieldIdx;
    logic       moveWord;
    logic       descDone;
    logic       flagFromBus;
    logic       flagAlignErr;
  } engStrobe_t;

endpackage

// File: rtl/ring_dma_ctrl.sv
module ring_dma_ctrl
  import ring_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  logic       ptrAligned,
  input  logic       memRdValid,
  input  logic       fifoReady,
  input  logic       sizeZero,
  input  logic       lastWord,
  output engStrobe_t strobe,
  output logic       memRdReq,
  output logic       fifoRdEn,
  output logic       busy,
  output logic [1:0] fieldIdx
);

  engState_t  state, stateNext;
  logic [1:0] idx, idxNext;

  always_comb begin
    strobe    = '0;
    fifoRdEn  = 1'b0;
    stateNext = state;
    idxNext   = idx;
    if (stopReq) begin
      stateNext = ST_IDLE;
      idxNext   = 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            if (ptrAligned) begin
              strobe.loadBase = 1'b1;
              stateNext       = ST_FETCH;
              idxNext         = 2'd0;
            end else begin
              strobe.flagAlignErr = 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (memRdValid) begin
            strobe.latchField = 1'b1;
            strobe.fieldIdx   = idx;
            if (idx == FLD_NEXT) begin
              idxNext = 2'd0;
              if (sizeZero) begin
                strobe.descDone    = 1'b1;
                strobe.flagFromBus = 1'b1;
              end else begin
                stateNext = ST_XFER;
              end
            end else begin
              idxNext = 2'(idx + 2'd1);
            end
          end
        end
        ST_XFER: begin
          if (fifoReady) begin
            strobe.moveWord = 1'b1;
            fifoRdEn        = 1'b1;
            if (lastWord) begin
              strobe.descDone = 1'b1;
              stateNext       = ST_FETCH;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= 2'd0;
    end else begin
      state <= stateNext;
      idx   <= idxNext;
    end
  end

  assign memRdReq = (state == ST_FETCH);
  assign busy     = (state != ST_IDLE);
  assign fieldIdx = idx;

  // data phase is entered only right after the last descriptor word arrived
  assert_enter_xfer_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && $past(state) != ST_XFER)
      |-> $past(strobe.latchField && strobe.fieldIdx == FLD_NEXT));

  assert_align_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagAlignErr |=> (state == ST_IDLE && !memRdReq));

  assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!memRdReq && !fifoRdEn));

endmodule

// File: rtl/ring_dma_path.sv
module ring_dma_path
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic [DATA_W-1:0] fifoData,
  input  engStrobe_t        strobe,
  input  logic              busy,
  input  logic [1:0]        fieldIdx,
  output logic              startReq,
  output logic              stopReq,
  output logic              ptrAligned,
  output logic              sizeZero,
  output logic              lastWord,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] fifoAddr,
  output logic              hostWrEn,
  output logic [ADDR_W-1:0] hostWrAddr,
  output logic [DATA_W-1:0] hostWrData,
  output logic              irq
);

  localparam int MAX_WORDS = MAX_BYTES / 4;
  localparam int WORD_W    = $clog2(MAX_WORDS + 1);

  logic [ADDR_W-1:0] descPtr, fetchBase, curAddr, localAddr;
  logic [WORD_W-1:0] wordsLeft, sizeWords;
  logic              nextIrq, enableBit, doneIrq, alignErr;
  logic              ctrlWr, descIrq;

  assign ctrlWr   = regWrEn && (regAddr == REG_CSR);
  assign startReq = ctrlWr && regWrData[CTL_ENABLE] && regWrData[CTL_START]
                    && !regWrData[CTL_ABORT];
  assign stopReq  = ctrlWr && (regWrData[CTL_ABORT] || !regWrData[CTL_ENABLE]);

  assign ptrAligned = (descPtr[DESC_ALIGN_W-1:0] == '0);
  assign sizeZero   = (wordsLeft == '0);
  assign lastWord   = (wordsLeft == WORD_W'(1));

  assign sizeWords = (memRdData > ADDR_W'(MAX_BYTES)) ? WORD_W'(MAX_WORDS)
                                                      : memRdData[WORD_W+1:2];

  assign descIrq   = strobe.flagFromBus ? memRdData[NEXT_IRQ_BIT] : nextIrq;
  assign memRdAddr = fetchBase + ADDR_W'({fieldIdx, 2'b00});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descPtr   <= '0;
      fetchBase <= '0;
      curAddr   <= '0;
      localAddr <= '0;
      wordsLeft <= '0;
      nextIrq   <= 1'b0;
      enableBit <= 1'b0;
      doneIrq   <= 1'b0;
      alignErr  <= 1'b0;
    end else begin
      if (regWrEn && regAddr == REG_PTR) descPtr <= regWrData;
      if (ctrlWr) enableBit <= regWrData[CTL_ENABLE] & ~regWrData[CTL_ABORT];
      if (strobe.loadBase) fetchBase <= descPtr;
      if (strobe.latchField) begin
        unique case (strobe.fieldIdx)
          FLD_HOST:  curAddr   <= memRdData;
          FLD_LOCAL: localAddr <= memRdData;
          FLD_SIZE:  wordsLeft <= sizeWords;
          default: begin
            fetchBase <= {memRdData[ADDR_W-1:DESC_ALIGN_W], {DESC_ALIGN_W{1'b0}}};
            nextIrq   <= memRdData[NEXT_IRQ_BIT];
          end
        endcase
      end
      if (strobe.moveWord) begin
        curAddr   <= curAddr + ADDR_W'(4);
        wordsLeft <= wordsLeft - WORD_W'(1);
      end
      if (strobe.descDone && descIrq) doneIrq <= 1'b1;
      else if (ctrlWr && regWrData[CTL_CLR_DONE]) doneIrq <= 1'b0;
      if (strobe.flagAlignErr) alignErr <= 1'b1;
      else if (ctrlWr && regWrData[CTL_CLR_ALIGN]) alignErr <= 1'b0;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_PTR:  regRdData = descPtr;
      REG_CSR:  regRdData = ADDR_W'({alignErr, doneIrq, busy, enableBit});
      REG_ADDR: regRdData = curAddr;
      default:  regRdData = '0;
    endcase
  end

  assign fifoAddr   = localAddr;
  assign hostWrEn   = strobe.moveWord;
  assign hostWrAddr = curAddr;
  assign hostWrData = fifoData;
  assign irq        = doneIrq;

  assert_local_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && $past(hostWrEn)) |-> $stable(fifoAddr));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && $past(hostWrEn)) |-> (hostWrAddr == $past(hostWrAddr) + ADDR_W'(4)));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(ctrlWr && regWrData[CTL_CLR_DONE])) |=> irq);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !strobe.descDone) |=> !irq);

endmodule

// File: rtl/ring_dma.sv
module ring_dma
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              fifoReady,
  output logic              fifoRdEn,
  output logic [ADDR_W-1:0] fifoAddr,
  input  logic [DATA_W-1:0] fifoData,
  output logic              hostWrEn,
  output logic [ADDR_W-1:0] hostWrAddr,
  output logic [DATA_W-1:0] hostWrData,
  output logic              irq
);

  engStrobe_t strobe;
  logic       startReq, stopReq, ptrAligned, sizeZero, lastWord, busy;
  logic [1:0] fieldIdx;

  ring_dma_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .ptrAligned (ptrAligned),
    .memRdValid (memRdValid),
    .fifoReady  (fifoReady),
    .sizeZero   (sizeZero),
    .lastWord   (lastWord),
    .strobe     (strobe),
    .memRdReq   (memRdReq),
    .fifoRdEn   (fifoRdEn),
    .busy       (busy),
    .fieldIdx   (fieldIdx)
  );

  ring_dma_path #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_BYTES (MAX_BYTES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .memRdData  (memRdData),
    .fifoData   (fifoData),
    .strobe     (strobe),
    .busy       (busy),
    .fieldIdx   (fieldIdx),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .ptrAligned (ptrAligned),
    .sizeZero   (sizeZero),
    .lastWord   (lastWord),
    .memRdAddr  (memRdAddr),
    .fifoAddr   (fifoAddr),
    .hostWrEn   (hostWrEn),
    .hostWrAddr (hostWrAddr),
    .hostWrData (hostWrData),
    .irq        (irq)
  );

  // the ctrl grants the FIFO read and the path issues the host write
  assert_demand_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |-> (fifoReady && fifoRdEn));

endmodule

// File: tb/ring_dma_test.sv
module ring_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLE_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        fifoReady = 1'b0;
  logic        fifoRdEn;
  logic [31:0] fifoAddr;
  logic [31:0] fifoData = '0;
  logic        hostWrEn;
  logic [31:0] hostWrAddr;
  logic [31:0] hostWrData;
  logic        irq;

  ring_dma uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .fifoReady(fifoReady), .fifoRdEn(fifoRdEn), .fifoAddr(fifoAddr),
    .fifoData(fifoData), .hostWrEn(hostWrEn), .hostWrAddr(hostWrAddr),
    .hostWrData(hostWrData), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int unsigned nCmp = 0, nBad = 0, cyc = 0;
  logic [31:0] mem [0:255];

  logic        trackOn = 1'b0;
  logic [31:0] fBase = '0;
  int unsigned fIdx = 0;
  logic [31:0] wDesc = '0;
  int unsigned wOff = 0;
  int unsigned wordsSeen = 0;
  int unsigned seqCount = 0;
  logic        expIrq = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > CYCLE_LIMIT) begin
      nBad++;
      $display("FAIL watchdog all requirements actual=%0d expected<%0d", cyc, CYCLE_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  function automatic int unsigned expWords(input logic [31:0] sz);
    if (sz > 32'd65536) return 16384;
    return sz >> 2;
  endfunction

  function automatic logic [31:0] nextBase(input logic [31:0] d);
    return rd(d + 32'd12) & ~32'hF;
  endfunction

  function automatic logic [31:0] seqVal(input int unsigned n);
    return (n * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walkerSettle();
    for (int g = 0; g < 64 && expWords(rd(wDesc + 32'd8)) == 0; g++)
      wDesc = nextBase(wDesc);
    wOff = 0;
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [31:0] host,
                         input logic [31:0] loc, input logic [31:0] size,
                         input logic [31:0] nxt, input bit irqFlag);
    mem[a[9:2]]       = host;
    mem[a[9:2] + 8'd1] = loc;
    mem[a[9:2] + 8'd2] = size;
    mem[a[9:2] + 8'd3] = nxt | 32'h5 | (irqFlag ? 32'h2 : 32'h0);
  endtask

  task automatic step(input logic rdy, input logic [1:0] ra, input logic we,
                      input logic [31:0] wd);
    logic        setIrq;
    logic [31:0] nx;
    setIrq = 1'b0;
    @(negedge clk);
    fifoReady  = rdy;
    regAddr    = ra;
    regWrEn    = we;
    regWrData  = wd;
    fifoData   = seqVal(seqCount);
    memRdValid = memRdReq && ($urandom_range(3) != 0);
    memRdData  = memRdValid ? rd(memRdAddr) : 32'h0;
    #1;
    chk(irq === expIrq, "R8 R9 irq level", {31'b0, irq}, {31'b0, expIrq});
    if (trackOn) begin
      if (memRdReq && memRdValid) begin
        chk(memRdAddr == fBase + 4 * fIdx, "R2 R7 fetch address", memRdAddr, fBase + 4 * fIdx);
        fIdx++;
        if (fIdx == 4) begin
          fBase = nextBase(fBase);
          fIdx = 0;
        end
      end
      if (hostWrEn) begin
        chk(fIdx == 0, "R2 write before fetch done", fIdx, 0);
        chk(fifoRdEn && fifoReady, "R3 demand", {30'b0, fifoRdEn, fifoReady}, 32'h3);
        chk(hostWrAddr == rd(wDesc) + 4 * wOff, "R5 R6 R7 host address",
            hostWrAddr, rd(wDesc) + 4 * wOff);
        chk(hostWrData == seqVal(wordsSeen), "R3 data order", hostWrData, seqVal(wordsSeen));
        chk(fifoAddr == rd(wDesc + 32'd4), "R4 local address", fifoAddr, rd(wDesc + 32'd4));
        if (ra == 2'd2)
          chk(regRdData == rd(wDesc) + 4 * wOff, "R12 live address",
              regRdData, rd(wDesc) + 4 * wOff);
        wordsSeen++;
        wOff++;
        if (wOff == expWords(rd(wDesc + 32'd8))) begin
          nx = rd(wDesc + 32'd12);
          if (nx[1]) setIrq = 1'b1;
          wDesc = nextBase(wDesc);
          walkerSettle();
        end
      end else begin
        chk(!fifoRdEn, "R3 no FIFO read without write", {31'b0, fifoRdEn}, 32'h0);
      end
      if (ra == 2'd1 && !we)
        chk(regRdData[2] == expIrq, "R8 status done bit", {31'b0, regRdData[2]}, {31'b0, expIrq});
    end
    if (fifoRdEn) seqCount++;
    if (setIrq) expIrq = 1'b1;
    else if (we && ra == 2'd1 && wd[3]) expIrq = 1'b0;
  endtask

  task automatic startRing(input logic [31:0] base);
    step(1'b0, 2'd0, 1'b1, base);
    fBase = base;
    fIdx = 0;
    wDesc = base;
    walkerSettle();
    trackOn = 1'b1;
    step(1'b0, 2'd1, 1'b1, 32'h3);
  endtask

  task automatic runFor(input int n, input int rdyPct);
    for (int i = 0; i < n; i++) begin
      logic r;
      int unsigned pick;
      r = ($urandom_range(99) < rdyPct);
      pick = $urandom_range(15);
      if (expIrq && pick < 3) step(r, 2'd1, 1'b1, 32'h9);
      else if (pick == 3) step(r, 2'd1, 1'b1, 32'h1);
      else if (pick == 4) step(r, 2'd1, 1'b0, 32'h0);
      else step(r, 2'd2, 1'b0, 32'h0);
    end
  endtask

  task automatic abortCheck();
    trackOn = 1'b0;
    step(1'b1, 2'd1, 1'b1, 32'h4);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 2'd2, 1'b0, 32'h0);
      chk(!hostWrEn && !memRdReq, "R11 quiet after abort",
          {30'b0, hostWrEn, memRdReq}, 32'h0);
    end
    step(1'b1, 2'd1, 1'b0, 32'h0);
    chk(regRdData[1:0] == 2'b00, "R11 status idle", regRdData, {regRdData[31:2], 2'b00});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    step(1'b0, 2'd1, 1'b0, 32'h0);
    chk(regRdData == 32'h0, "R1 status", regRdData, 32'h0);
    chk(!irq && !memRdReq && !hostWrEn, "R1 outputs idle",
        {29'b0, irq, memRdReq, hostWrEn}, 32'h0);
    step(1'b1, 2'd2, 1'b0, 32'h0);
    chk(regRdData == 32'h0, "R1 address readback", regRdData, 32'h0);
    step(1'b1, 2'd0, 1'b0, 32'h0);
    chk(regRdData == 32'h0, "R1 pointer", regRdData, 32'h0);

    // R10 misaligned pointer, R9 write-one-to-clear
    step(1'b1, 2'd0, 1'b1, 32'h0000_0104);
    step(1'b1, 2'd1, 1'b1, 32'h3);
    step(1'b1, 2'd1, 1'b0, 32'h0);
    chk(regRdData[3] == 1'b1, "R10 alignment flag", regRdData, regRdData | 32'h8);
    chk(regRdData[1] == 1'b0 && !memRdReq, "R10 no fetch",
        {30'b0, regRdData[1], memRdReq}, 32'h0);
    step(1'b1, 2'd1, 1'b1, 32'h1);
    step(1'b1, 2'd1, 1'b0, 32'h0);
    chk(regRdData[3] == 1'b1, "R9 flag kept without clear bit", regRdData, regRdData | 32'h8);
    step(1'b1, 2'd1, 1'b1, 32'h11);
    step(1'b1, 2'd1, 1'b0, 32'h0);
    chk(regRdData[3] == 1'b0, "R9 flag cleared", regRdData, regRdData & ~32'h8);

    // random ring
    for (int i = 0; i < 4; i++) begin
      logic [31:0] a;
      a = 32'h100 + 32'(i) * 32'h10;
      setDesc(a, 32'h2000_0000 + (32'(i) << 12) + (32'($urandom_range(15)) << 2),
              32'h3000_0000 + 32'(i) * 32'h40,
              32'($urandom_range(1, 12)) * 4 + 32'($urandom_range(3)),
              (i == 3) ? 32'h100 : a + 32'h10, $urandom_range(1) == 1);
    end
    startRing(32'h100);
    runFor(1500, 70);
    chk(wordsSeen > 100, "R7 ring keeps running", wordsSeen, 101);
    abortCheck();

    // directed: short, zero-size and odd-size descriptors
    setDesc(32'h200, 32'h6000_0000, 32'h7000_0010, 32'd8, 32'h210, 1'b1);
    setDesc(32'h210, 32'h6100_0000, 32'h7000_0020, 32'd0, 32'h220, 1'b0);
    setDesc(32'h220, 32'h6200_0000, 32'h7000_0030, 32'd7, 32'h200, 1'b1);
    startRing(32'h200);
    runFor(300, 50);
    abortCheck();

    // oversize self-looping descriptor
    setDesc(32'h300, 32'h4000_0000, 32'h5000_0000, 32'h0002_0000, 32'h300, 1'b1);
    begin
      int unsigned w0;
      w0 = wordsSeen;
      startRing(32'h300);
      for (int i = 0; i < 30000 && wordsSeen - w0 < 16390; i++)
        step($urandom_range(9) != 0, 2'd2, 1'b0, 32'h0);
      chk(wordsSeen - w0 >= 16390, "R5 clamp wrap reached", wordsSeen - w0, 16390);
      chk(expIrq, "R5 R8 clamped count completes", {31'b0, expIrq}, 32'h1);
    end
    abortCheck();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule